// File: doc/BRIEF.md
# Indirect Interrupt Routing Register File

This block holds the routing configuration for a set of interrupt input pins behind a two-register window on a small 32-bit bus slave. Software first writes an index into the select register, then reads or writes the data window; the index chooses between an identity register, a read-only version register, a mirror of the identity for arbitration, and one 64-bit routing entry per pin. Each routing entry is split into two 32-bit halves with separate indices. The full table is presented on a flat parallel output so that downstream delivery logic can use every entry at once.

Besides plain storage, the block carries the side effects that a rewrite has on an entry. A write to the low half always clears the entry's remote-request status bit. A write that flips the mask bit produces a one-cycle notification. A write to a level-triggered entry whose pin is currently requesting produces a one-cycle re-evaluation request. The remote-request bit is set by a delivery acknowledge from the downstream logic. Delivery itself is done elsewhere.

Top module: `intr_route_regs`

## Requirements
- R1: Only `bus_addr[7:0]` is decoded. Offset 0x00 is the select register: a write stores `bus_wdata[7:0]`, and a read returns it zero-extended. Offset 0x10 is the data window. A read at any other aligned offset returns 0.
- R2: An access with `bus_addr[3:0]` not zero drives `align_err` high in that same cycle. Such an access changes no state, and a read of that kind returns 0.
- R3: A write is taken only when `bus_len` is 4 or 8. Writes of any other length change nothing.
- R4: Select index 0x01 reads `{8'h00, NPINS-1, 8'h00, VERSION}`. Writes to index 0x01 are ignored.
- R5: Select index 0x00 holds a 4-bit identity in bits 27:24, and reads show only those bits. Index 0x02 reads back the same value, and writes to index 0x02 are ignored. Indices 0x03 to 0x0F read 0.
- R6: Entry n is at select index 0x10+2n. The even index reaches bits 31:0 and the odd index reaches bits 63:32. Entry n appears on `route_tbl[64n+63:64n]`. The bit fields are: vector 7:0, delivery mode 10:8, destination mode 11, polarity 13, remote-request 14, trigger 15 (1 = level), mask 16, destination 63:56.
- R7: A window access whose index lies past entry NPINS-1 is discarded on write and reads 0.
- R8: A write to the low half stores bit 14 as 0, whatever the data holds. A write to the high half leaves bit 14 unchanged.
- R9: A pulse on `dlv_ack[n]` sets bit 14 of entry n when its bit 15 is 1. When bit 15 is 0, the pulse has no effect.
- R10: In the cycle after a window write that changes an entry's mask bit, `mask_evt` is high for one cycle. At that time `mask_evt_pin` gives the entry number and `mask_evt_val` gives the new mask. A write that leaves the mask unchanged gives no pulse.
- R11: In the cycle after any window write to entry n, `svc_req` pulses with `svc_pin` = n if both of these hold: the entry, after the write, has bit 15 set, and the pending bit n is set. The pending vector is `irq_lvl` registered once.
- R12: After reset, every entry reads 0x00010000 in its low half and 0 in its high half. The select register, the identity and the pending vector are 0, and no pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_addr | input | 8 | Byte offset within the block |
| bus_len | input | 4 | Access length in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_rd` is high |
| align_err | output | 1 | Misaligned access flag |
| irq_lvl | input | NPINS | Asserted request level per pin |
| dlv_ack | input | NPINS | Delivery acknowledge per pin |
| route_tbl | output | 64*NPINS | All routing entries, flattened |
| mask_evt | output | 1 | Mask-change pulse |
| mask_evt_pin | output | PW | Entry whose mask changed |
| mask_evt_val | output | 1 | New mask value |
| svc_req | output | 1 | Re-evaluation request pulse |
| svc_pin | output | PW | Entry to re-evaluate |

## Verification
The hardest situation to reach is a service request. It needs three things lined up in one cycle: a level-triggered entry, a pending bit captured one cycle earlier from `irq_lvl`, and a window write to that same entry. The bench raises `irq_lvl` on a chosen pin and waits one clock. It then rewrites only the high half, so the trigger bit is not touched. A level-triggered pin, an edge-triggered pin and a quiet level-triggered pin are checked against each other. The remote-request bit is set only through `dlv_ack` and can be cleared only by a low-half write. So the bench acknowledges first, then rewrites the high half, then the low half, and reads the bit back after each step.

// File: rtl/intr_route_pkg.sv
package intr_route_pkg;

   // Bus offsets within the 8-bit decoded space
   localparam logic [7:0] OFF_SEL = 8'h00;
   localparam logic [7:0] OFF_WIN = 8'h10;

   // Select indices
   localparam logic [7:0] IDX_ID  = 8'h00;
   localparam logic [7:0] IDX_VER = 8'h01;
   localparam logic [7:0] IDX_ARB = 8'h02;
   localparam logic [7:0] IDX_TBL = 8'h10;

   // Entry bit positions
   localparam int F_POL    = 13;
   localparam int F_REMOTE = 14;
   localparam int F_TRIG   = 15;
   localparam int F_MASK   = 16;

   localparam int ENT_W  = 64;
   localparam int HALF_W = 32;

   typedef enum logic [2:0] {
      TGT_NONE,
      TGT_ID,
      TGT_VER,
      TGT_ARB,
      TGT_ENT
   } win_tgt_e;

endpackage

// File: rtl/intr_route_decode.sv
module intr_route_decode
   import intr_route_pkg::*;
#(
   parameter int NPINS = 24,
   parameter int SEL_W = 8,
   localparam int PW = $clog2(NPINS)
) (
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [7:0]       bus_addr,
   input  logic [3:0]       bus_len,
   input  logic [SEL_W-1:0] sel_q,
   output logic             align_err,
   output logic             sel_we,
   output logic             win_we,
   output logic             sel_re,
   output logic             win_re,
   output win_tgt_e         tgt,
   output logic [PW-1:0]    ent_idx,
   output logic             ent_hi
);

   localparam logic [SEL_W-2:0] NP_L = NPINS[SEL_W-2:0];

   logic             aligned;
   logic             len_ok;
   logic             wr_ok;
   logic             rd_ok;
   logic [SEL_W-1:0] tbl_off;
   logic [SEL_W-2:0] raw_idx;
   logic             in_tbl;

   always_comb begin
      aligned   = (bus_addr[3:0] == 4'h0);
      align_err = (bus_wr | bus_rd) & ~aligned;
      len_ok    = (bus_len == 4'd4) || (bus_len == 4'd8);
      wr_ok     = bus_wr & aligned & len_ok;
      rd_ok     = bus_rd & aligned;
      sel_we    = wr_ok && (bus_addr == OFF_SEL);
      win_we    = wr_ok && (bus_addr == OFF_WIN);
      sel_re    = rd_ok && (bus_addr == OFF_SEL);
      win_re    = rd_ok && (bus_addr == OFF_WIN);
   end

   // Entry index arithmetic on the select value
   always_comb begin
      tbl_off = sel_q - IDX_TBL[SEL_W-1:0];
      raw_idx = tbl_off[SEL_W-1:1];
      ent_hi  = tbl_off[0];
      in_tbl  = (sel_q >= IDX_TBL[SEL_W-1:0]) && (raw_idx < NP_L);
      ent_idx = raw_idx[PW-1:0];
   end

   always_comb begin
      if (in_tbl)                             tgt = TGT_ENT;
      else if (sel_q == IDX_ID[SEL_W-1:0])    tgt = TGT_ID;
      else if (sel_q == IDX_VER[SEL_W-1:0])   tgt = TGT_VER;
      else if (sel_q == IDX_ARB[SEL_W-1:0])   tgt = TGT_ARB;
      else                                    tgt = TGT_NONE;
   end

endmodule

// File: rtl/intr_route_entry.sv
module intr_route_entry
   import intr_route_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_lo,
   input  logic              we_hi,
   input  logic [HALF_W-1:0] wdata,
   input  logic              ack,
   output logic [ENT_W-1:0]  ent,
   output logic              mask_flip,
   output logic              lvl_after
);

   localparam logic [ENT_W-1:0] ENT_RST = ENT_W'(1) << F_MASK;

   logic [ENT_W-1:0]  ent_q;
   logic [HALF_W-1:0] lo_new;

   always_comb begin
      lo_new           = wdata;
      lo_new[F_REMOTE] = 1'b0;
      mask_flip        = we_lo && (wdata[F_MASK] != ent_q[F_MASK]);
      lvl_after        = we_lo ? wdata[F_TRIG] : ent_q[F_TRIG];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_q <= ENT_RST;
      end else begin
         if (we_hi)
            ent_q[ENT_W-1:HALF_W] <= wdata;
         if (we_lo)
            ent_q[HALF_W-1:0] <= lo_new;
         else if (ack && ent_q[F_TRIG])
            ent_q[F_REMOTE] <= 1'b1;
      end
   end

   assign ent = ent_q;

endmodule

// File: rtl/intr_route_event.sv
module intr_route_event #(
   parameter int NPINS = 24,
   localparam int PW = $clog2(NPINS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hit,
   input  logic [PW-1:0] idx,
   input  logic          flip,
   input  logic          new_mask,
   input  logic          lvl,
   input  logic          pend,
   output logic          mask_evt,
   output logic [PW-1:0] mask_evt_pin,
   output logic          mask_evt_val,
   output logic          svc_req,
   output logic [PW-1:0] svc_pin
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_evt     <= 1'b0;
         mask_evt_pin <= '0;
         mask_evt_val <= 1'b0;
         svc_req      <= 1'b0;
         svc_pin      <= '0;
      end else begin
         mask_evt <= hit & flip;
         svc_req  <= hit & lvl & pend;
         if (hit & flip) begin
            mask_evt_pin <= idx;
            mask_evt_val <= new_mask;
         end
         if (hit & lvl & pend)
            svc_pin <= idx;
      end
   end

endmodule

// File: rtl/intr_route_rdmux.sv
module intr_route_rdmux
   import intr_route_pkg::*;
#(
   parameter int NPINS = 24,
   parameter logic [7:0] VERSION = 8'h11,
   parameter int SEL_W = 8
) (
   input  logic             sel_re,
   input  logic             win_re,
   input  logic [SEL_W-1:0] sel_q,
   input  win_tgt_e         tgt,
   input  logic [3:0]       id_q,
   input  logic [ENT_W-1:0] ent_sel,
   input  logic             ent_hi,
   output logic [31:0]      rdata
);

   localparam logic [7:0]  PMAX    = 8'(NPINS - 1);
   localparam logic [31:0] VER_WRD = {8'h00, PMAX, 8'h00, VERSION};

   logic [31:0] win_val;

   always_comb begin
      unique case (tgt)
         TGT_ID,
         TGT_ARB: win_val = {4'h0, id_q, 24'h0};
         TGT_VER: win_val = VER_WRD;
         TGT_ENT: win_val = ent_hi ? ent_sel[ENT_W-1:HALF_W] : ent_sel[HALF_W-1:0];
         default: win_val = 32'h0;
      endcase
   end

   always_comb begin
      if (sel_re)      rdata = 32'(sel_q);
      else if (win_re) rdata = win_val;
      else             rdata = 32'h0;
   end

endmodule

// File: rtl/intr_route_regs.sv
module intr_route_regs
   import intr_route_pkg::*;
#(
   parameter int NPINS = 24,
   parameter logic [7:0] VERSION = 8'h11,
   localparam int PW = $clog2(NPINS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic                 bus_rd,
   input  logic [7:0]           bus_addr,
   input  logic [3:0]           bus_len,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   output logic                 align_err,
   input  logic [NPINS-1:0]     irq_lvl,
   input  logic [NPINS-1:0]     dlv_ack,
   output logic [64*NPINS-1:0]  route_tbl,
   output logic                 mask_evt,
   output logic [PW-1:0]        mask_evt_pin,
   output logic                 mask_evt_val,
   output logic                 svc_req,
   output logic [PW-1:0]        svc_pin
);

   localparam int SEL_W = 8;

   if (NPINS < 2 || NPINS > 120) begin : g_bad_npins
      $error("intr_route_regs: NPINS must lie in 2..120");
   end

   logic [SEL_W-1:0] sel_q;
   logic [3:0]       id_q;
   logic [NPINS-1:0] pend_q;
   logic             sel_we;
   logic             win_we;
   logic             sel_re;
   logic             win_re;
   win_tgt_e         tgt;
   logic [PW-1:0]    ent_idx;
   logic             ent_hi;
   logic             ent_hit;

   logic [ENT_W-1:0] ent_arr [NPINS];
   logic [NPINS-1:0] flip_vec;
   logic [NPINS-1:0] lvl_vec;

   intr_route_decode #(.NPINS(NPINS), .SEL_W(SEL_W)) u_decode (
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_len   (bus_len),
      .sel_q     (sel_q),
      .align_err (align_err),
      .sel_we    (sel_we),
      .win_we    (win_we),
      .sel_re    (sel_re),
      .win_re    (win_re),
      .tgt       (tgt),
      .ent_idx   (ent_idx),
      .ent_hi    (ent_hi)
   );

   assign ent_hit = win_we && (tgt == TGT_ENT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         id_q   <= '0;
         pend_q <= '0;
      end else begin
         pend_q <= irq_lvl;
         if (sel_we)
            sel_q <= bus_wdata[SEL_W-1:0];
         if (win_we && (tgt == TGT_ID))
            id_q <= bus_wdata[27:24];
      end
   end

   for (genvar n = 0; n < NPINS; n++) begin : g_ent
      logic we_lo;
      logic we_hi;

      assign we_lo = ent_hit && !ent_hi && (ent_idx == PW'(n));
      assign we_hi = ent_hit &&  ent_hi && (ent_idx == PW'(n));

      intr_route_entry u_ent (
         .clk       (clk),
         .rst_n     (rst_n),
         .we_lo     (we_lo),
         .we_hi     (we_hi),
         .wdata     (bus_wdata),
         .ack       (dlv_ack[n]),
         .ent       (ent_arr[n]),
         .mask_flip (flip_vec[n]),
         .lvl_after (lvl_vec[n])
      );

      assign route_tbl[ENT_W*n +: ENT_W] = ent_arr[n];
   end

   intr_route_event #(.NPINS(NPINS)) u_event (
      .clk          (clk),
      .rst_n        (rst_n),
      .hit          (ent_hit),
      .idx          (ent_idx),
      .flip         (flip_vec[ent_idx]),
      .new_mask     (bus_wdata[F_MASK]),
      .lvl          (lvl_vec[ent_idx]),
      .pend         (pend_q[ent_idx]),
      .mask_evt     (mask_evt),
      .mask_evt_pin (mask_evt_pin),
      .mask_evt_val (mask_evt_val),
      .svc_req      (svc_req),
      .svc_pin      (svc_pin)
   );

   intr_route_rdmux #(.NPINS(NPINS), .VERSION(VERSION), .SEL_W(SEL_W)) u_rdmux (
      .sel_re  (sel_re),
      .win_re  (win_re),
      .sel_q   (sel_q),
      .tgt     (tgt),
      .id_q    (id_q),
      .ent_sel (ent_arr[ent_idx]),
      .ent_hi  (ent_hi),
      .rdata   (bus_rdata)
   );

endmodule

// File: rtl/intr_route_regs_chk.sv
module intr_route_regs_chk #(
   parameter int NPINS = 24,
   parameter logic [7:0] VERSION = 8'h11,
   localparam int PW = $clog2(NPINS)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_wr,
   input logic                bus_rd,
   input logic [7:0]          bus_addr,
   input logic [31:0]         bus_rdata,
   input logic                align_err,
   input logic [7:0]          sel_q,
   input logic                win_we,
   input logic                ent_hit,
   input logic                ent_hi,
   input logic [PW-1:0]       ent_idx,
   input logic [64*NPINS-1:0] route_tbl,
   input logic                mask_evt,
   input logic [PW-1:0]       mask_evt_pin,
   input logic                mask_evt_val,
   input logic                svc_req,
   input logic [PW-1:0]       svc_pin
);

   localparam logic [31:0] VER_EXP = {8'h00, 8'(NPINS - 1), 8'h00, VERSION};

   // R2: a misaligned write leaves the select register alone
   p_misalign_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && align_err) |=> $stable(sel_q));

   // R1: reads at undecoded offsets return zero
   p_other_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr != 8'h00 && bus_addr != 8'h10) |-> (bus_rdata == 32'h0));

   // R4: version word through the window
   p_version_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == 8'h10 && sel_q == 8'h01) |-> (bus_rdata == VER_EXP));

   // R8: low-half write leaves remote-request cleared
   p_remote_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_hit && !ent_hi) |=> (route_tbl[int'($past(ent_idx))*64 + 14] == 1'b0));

   // R10: mask pulse follows a window write and matches the table
   p_mask_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mask_evt |-> $past(win_we));
   p_mask_val_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mask_evt |-> (route_tbl[int'(mask_evt_pin)*64 + 16] == mask_evt_val));

   // R11: service only for level-triggered entries, after a write
   p_svc_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
      svc_req |-> (route_tbl[int'(svc_pin)*64 + 15] && $past(ent_hit)));

endmodule

bind intr_route_regs intr_route_regs_chk #(.NPINS(NPINS), .VERSION(VERSION)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_wr       (bus_wr),
   .bus_rd       (bus_rd),
   .bus_addr     (bus_addr),
   .bus_rdata    (bus_rdata),
   .align_err    (align_err),
   .sel_q        (sel_q),
   .win_we       (win_we),
   .ent_hit      (ent_hit),
   .ent_hi       (ent_hi),
   .ent_idx      (ent_idx),
   .route_tbl    (route_tbl),
   .mask_evt     (mask_evt),
   .mask_evt_pin (mask_evt_pin),
   .mask_evt_val (mask_evt_val),
   .svc_req      (svc_req),
   .svc_pin      (svc_pin)
);

// File: tb/intr_route_regs_tb.sv
module intr_route_regs_tb;

   localparam int NP = 24;
   localparam int PW = $clog2(NP);
   localparam logic [7:0] VER = 8'h11;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_wr = 1'b0;
   logic              bus_rd = 1'b0;
   logic [7:0]        bus_addr = '0;
   logic [3:0]        bus_len = 4'd4;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic              align_err;
   logic [NP-1:0]     irq_lvl = '0;
   logic [NP-1:0]     dlv_ack = '0;
   logic [64*NP-1:0]  route_tbl;
   logic              mask_evt;
   logic [PW-1:0]     mask_evt_pin;
   logic              mask_evt_val;
   logic              svc_req;
   logic [PW-1:0]     svc_pin;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   logic          ev_mask, ev_mval, ev_svc, ev_aerr;
   logic [PW-1:0] ev_mpin, ev_spin;
   logic [31:0]   rv;

   always #5 clk = ~clk;

   intr_route_regs #(.NPINS(NP), .VERSION(VER)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_len(bus_len), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .align_err(align_err), .irq_lvl(irq_lvl),
      .dlv_ack(dlv_ack), .route_tbl(route_tbl), .mask_evt(mask_evt),
      .mask_evt_pin(mask_evt_pin), .mask_evt_val(mask_evt_val),
      .svc_req(svc_req), .svc_pin(svc_pin)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] len);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_len = len;
      #1 ev_aerr = align_err;
      @(posedge clk);
      #1;
      ev_mask = mask_evt; ev_mpin = mask_evt_pin; ev_mval = mask_evt_val;
      ev_svc = svc_req; ev_spin = svc_pin;
      @(negedge clk);
      bus_wr = 1'b0; bus_len = 4'd4;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #2 d = bus_rdata; ev_aerr = align_err;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic win_rd(input logic [7:0] idx, output logic [31:0] d);
      wr(8'h00, {24'h0, idx}, 4'd4);
      rd(8'h10, d);
   endtask

   task automatic win_wr(input logic [7:0] idx, input logic [31:0] d);
      wr(8'h00, {24'h0, idx}, 4'd4);
      wr(8'h10, d, 4'd4);
   endtask

   function automatic logic [31:0] lo_pat(input int n);
      return 32'h0000_4000 | ((n & 1) << 15) | ((n % 8) << 8) | (32'h20 + n);
   endfunction

   function automatic logic [31:0] hi_pat(input int n);
      return (32'hA500_0000 ^ (n << 24)) ^ (n * 32'h111);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual %h expected %h", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R12: reset state, every entry
      rd(8'h00, rv); chk(rv == 0, "R12 select", rv, 0);
      chk(!mask_evt && !svc_req, "R12 pulses", {mask_evt, svc_req}, 0);
      for (int n = 0; n < NP; n++) begin
         win_rd(8'(16 + 2*n), rv); chk(rv == 32'h0001_0000, "R12 entry lo", rv, 32'h0001_0000);
         win_rd(8'(17 + 2*n), rv); chk(rv == 0, "R12 entry hi", rv, 0);
      end
      win_rd(8'h00, rv); chk(rv == 0, "R12 id", rv, 0);

      // R1: select holds low byte
      wr(8'h00, 32'hFFFF_FF37, 4'd4); rd(8'h00, rv); chk(rv == 32'h37, "R1 select", rv, 32'h37);
      rd(8'h20, rv); chk(rv == 0, "R1 other offset", rv, 0);
      rd(8'hF0, rv); chk(rv == 0, "R1 other offset", rv, 0);

      // R4: version word, writes ignored
      win_wr(8'h01, 32'hFFFF_FFFF);
      rd(8'h10, rv); chk(rv == {8'h0, 8'(NP-1), 8'h0, VER}, "R4 version", rv, {8'h0, 8'(NP-1), 8'h0, VER});

      // R5: id and its mirror
      win_wr(8'h00, 32'hFA5F_FFFF);
      rd(8'h10, rv); chk(rv == 32'h0A00_0000, "R5 id", rv, 32'h0A00_0000);
      win_wr(8'h02, 32'h0300_0000);
      rd(8'h10, rv); chk(rv == 32'h0A00_0000, "R5 arb mirror", rv, 32'h0A00_0000);
      win_rd(8'h07, rv); chk(rv == 0, "R5 unused index", rv, 0);

      // R6/R8/R10: sweep every entry
      for (int n = 0; n < NP; n++) begin
         win_wr(8'(17 + 2*n), hi_pat(n));
         chk(!ev_mask, "R10 hi no pulse", ev_mask, 0);
         win_wr(8'(16 + 2*n), lo_pat(n));
         chk(ev_mask && ev_mpin == PW'(n) && !ev_mval, "R10 mask pulse",
             {ev_mask, 3'b0, ev_mpin, 3'b0, ev_mval}, {1'b1, 3'b0, PW'(n), 4'b0});
         chk(!ev_svc, "R11 no pending", ev_svc, 0);
         rd(8'h10, rv); chk(rv == (lo_pat(n) & ~32'h4000), "R8 lo readback", rv, lo_pat(n) & ~32'h4000);
         chk(route_tbl[64*n +: 64] == {hi_pat(n), lo_pat(n) & ~32'h4000}, "R6 table out",
             route_tbl[64*n +: 64], {hi_pat(n), lo_pat(n) & ~32'h4000});
      end
      win_rd(8'(17 + 2*5), rv); chk(rv == hi_pat(5), "R6 hi readback", rv, hi_pat(5));

      // R7: past last entry
      win_wr(8'(16 + 2*NP), 32'h0000_0000);
      chk(!ev_mask, "R7 no pulse", ev_mask, 0);
      rd(8'h10, rv); chk(rv == 0, "R7 read zero", rv, 0);
      chk(route_tbl[64*(NP-1) +: 64] == {hi_pat(NP-1), lo_pat(NP-1) & ~32'h4000}, "R7 last intact",
          route_tbl[64*(NP-1) +: 64], {hi_pat(NP-1), lo_pat(NP-1) & ~32'h4000});

      // R3: bad length dropped
      wr(8'h00, 32'h16, 4'd4);
      wr(8'h10, 32'h0001_0000, 4'd2);
      chk(!ev_mask, "R3 no pulse", ev_mask, 0);
      rd(8'h10, rv); chk(rv == (lo_pat(3) & ~32'h4000), "R3 dropped", rv, lo_pat(3) & ~32'h4000);
      wr(8'h00, 32'h55, 4'd1); rd(8'h00, rv); chk(rv == 32'h16, "R3 select kept", rv, 32'h16);
      wr(8'h00, 32'h55, 4'd8); rd(8'h00, rv); chk(rv == 32'h55, "R3 len 8", rv, 32'h55);

      // R2: misaligned
      wr(8'h04, 32'h12, 4'd4); chk(ev_aerr == 1'b1, "R2 flag", ev_aerr, 1);
      rd(8'h00, rv); chk(rv == 32'h55, "R2 select kept", rv, 32'h55);
      rd(8'h14, rv); chk(rv == 0 && ev_aerr, "R2 read zero", {31'h0, ev_aerr, rv}, 64'h1_0000_0000);
      rd(8'h10, rv); chk(!ev_aerr, "R2 aligned no flag", ev_aerr, 0);

      // R9/R8: remote bit on level pin 3, edge pin 0
      @(negedge clk) dlv_ack = NP'(32'h9);
      @(negedge clk) dlv_ack = '0;
      win_rd(8'(16 + 2*3), rv); chk(rv[14] == 1'b1, "R9 level set", rv, rv | 32'h4000);
      win_rd(8'(16 + 2*0), rv); chk(rv[14] == 1'b0, "R9 edge ignored", rv, rv & ~32'h4000);
      win_wr(8'(17 + 2*3), 32'h1234_5678);
      chk(route_tbl[64*3 + 14] == 1'b1, "R8 hi keeps", route_tbl[64*3 + 14], 1);
      win_wr(8'(16 + 2*3), lo_pat(3));
      chk(route_tbl[64*3 + 14] == 1'b0, "R8 lo clears", route_tbl[64*3 + 14], 0);
      chk(!ev_mask, "R10 unchanged mask", ev_mask, 0);

      // R11: service requests
      @(negedge clk) irq_lvl = NP'(32'h0000_000C);
      wr(8'h00, 32'(17 + 2*3), 4'd4);
      wr(8'h10, 32'h0F00_0000, 4'd4);
      chk(ev_svc && ev_spin == PW'(3), "R11 level pending", {ev_svc, 3'b0, ev_spin}, {1'b1, 3'b0, PW'(3)});
      win_wr(8'(17 + 2*2), 32'h0E00_0000);
      chk(!ev_svc, "R11 edge no service", ev_svc, 0);
      win_wr(8'(17 + 2*5), 32'h0D00_0000);
      chk(!ev_svc, "R11 quiet level", ev_svc, 0);
      win_wr(8'(16 + 2*2), 32'h0000_8020);
      chk(ev_svc && ev_spin == PW'(2), "R11 became level", {ev_svc, 3'b0, ev_spin}, {1'b1, 3'b0, PW'(2)});
      @(negedge clk) irq_lvl = '0;

      // R10: mask set back
      win_wr(8'(16 + 2*4), 32'h0001_0024);
      chk(ev_mask && ev_mpin == PW'(4) && ev_mval, "R10 mask set",
          {ev_mask, 3'b0, ev_mpin, 3'b0, ev_mval}, {1'b1, 3'b0, PW'(4), 4'b1});

      // R12: reset again
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b1;
      chk(route_tbl[63:0] == 64'h0001_0000, "R12 re-reset", route_tbl[63:0], 64'h0001_0000);
      win_rd(8'h00, rv); chk(rv == 0, "R12 id cleared", rv, 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule